// File: doc/BRIEF.md
# Display Power-Up Command Sequencer

This block brings a small TFT panel controller out of power-on. A one-cycle `start` pulse drives the panel's reset pin low for a set time, lets it recover, and then walks a fixed list of 21 commands. Each command may carry up to fifteen parameter bytes, and three of the commands are followed by millisecond waits. When the last wait expires, `done` is raised and the panel is ready for pixel traffic, which another block supplies.

Inside, a step walker turns the list into a stream of words. Each word carries a byte, a data/command flag and an end-of-command mark, and moves on a valid/ready handshake. A serializer frames every word as nine SPI bits: the flag first, then the byte most significant bit first. A single down-counter, loaded in units of `CLKS_PER_MS` cycles, times the reset pulse, the recovery time and all of the command waits.

Top module: `lcdseq_top`

## Requirements
- R1: After reset, `spi_cs_n`=1, `spi_sck`=0, `lcd_rst_n`=1, `busy`=0 and `done`=0.
- R2: When a `start` is accepted, `lcd_rst_n` stays low for exactly `RST_MS*CLKS_PER_MS` cycles. The first chip-select frame then begins between `RST_WAIT_MS*CLKS_PER_MS` and that value plus 4 cycles after `lcd_rst_n` rises.
- R3: Commands and their parameters are sent in this order: 0x01; 0x28; 0xCF 0x00,0x83,0x30; 0xED 0x64,0x03,0x12,0x81; 0xE8 0x85,0x01,0x79; 0xCB 0x39,0x2C,0x00,0x34,0x02; 0xF7 0x20; 0xEA 0x00,0x00; 0xC0 0x26; 0xC1 0x11; 0xC5 0x35,0x3E; 0xC7 0xBE; 0x3A 0x55; 0xB1 0x00,0x1B; 0x26 0x01; 0xE0 with the positive gamma table; 0xE1 with the negative gamma table; 0xB7 0x07; 0xB6 0x0A,0x82,0x27,0x00; 0x11; 0x29.
- R4: Every SPI word is 9 bits. Bit one is the data/command flag (0 for a command byte, 1 for a parameter byte), and bits two to nine are the byte, MSB first.
- R5: `spi_sck` idles low. `spi_mosi` changes only while `spi_sck` is low, so a receiver samples it on the rising edge. Each high phase of `spi_sck` lasts `SCK_HALF` cycles.
- R6: `spi_cs_n` falls before the first bit of a command. It stays low through the last bit of that command's last parameter, rises only at the end of a whole command, and is high while `spi_sck` toggles never.
- R7: After the frame of 0x01 the next frame starts 5 ms later, and after 0x11 it starts 100 ms later. After 0x29, `done` rises 20 ms later. In each case the delay is measured from the rise of `spi_cs_n`, where 1 ms is `CLKS_PER_MS` cycles, and up to `SCK_HALF+4` extra cycles are allowed.
- R8: Between commands that have no wait, the gap from the rise of `spi_cs_n` to the next fall is at most `SCK_HALF+4` cycles.
- R9: `done` rises together with the fall of `busy`. It holds until the next accepted `start`, which clears it on the following cycle.
- R10: A `start` pulse while `busy` is 1 is ignored: `lcd_rst_n` stays high and the list carries on without a restart.
- R11: The positive gamma table is 0x1F,0x1A,0x18,0x0A,0x0F,0x06,0x45,0x87,0x32,0x0A,0x07,0x02,0x07,0x05,0x00. The negative gamma table is 0x00,0x25,0x27,0x05,0x10,0x09,0x3A,0x78,0x4D,0x05,0x18,0x0D,0x38,0x3A,0x1F. Both are sent in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the power-up list |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | List finished, held until the next start |
| lcd_rst_n | output | 1 | Active-low reset to the panel |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI serial data to the panel |

## Verification
Results arrive at different distances from the stimulus. The reset pulse width is exact at `RST_MS*CLKS_PER_MS` cycles. A word is due nine clock periods after its chip-select frame opens. Each wait closes a fixed number of cycles after the chip select rises, plus a pipeline offset of two or three cycles and the serializer's trailing half period. The monitor samples on the falling edge of the system clock and timestamps every edge of the SPI pins. It compares each decoded 9-bit word against the scoreboard queue at the moment its ninth rising clock edge is seen. Gaps are checked against windows derived from the millisecond count, with a slack of `SCK_HALF+4` cycles rather than an exact count, so that the serializer's handshake latency does not hide a wrong millisecond count.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;

  localparam int NSTEP = 21;   // commands in the list
  localparam int NPAR  = 62;   // parameter bytes over all commands
  localparam int GLEN  = 15;   // bytes per gamma table
  localparam int GPOS0 = 27;   // first positive gamma byte in the parameter stream
  localparam int GNEG0 = GPOS0 + GLEN;

  typedef struct packed {
    logic [7:0] code;
    logic [3:0] npar;
    logic [6:0] wait_ms;
  } step_t;

  typedef struct packed {
    logic       last;   // final byte of one command frame
    logic       dc;     // 0 command, 1 parameter
    logic [7:0] data;
  } word_t;

  typedef enum logic [2:0] {
    C_IDLE, C_RST, C_RSTW, C_CMD, C_PAR, C_FLUSH, C_WAIT
  } cstate_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOW, S_HIGH, S_TAIL, S_GAP
  } sstate_t;

  function automatic step_t step_at(int i);
    case (i)
      0:  return '{8'h01, 4'd0,  7'd5};
      1:  return '{8'h28, 4'd0,  7'd0};
      2:  return '{8'hCF, 4'd3,  7'd0};
      3:  return '{8'hED, 4'd4,  7'd0};
      4:  return '{8'hE8, 4'd3,  7'd0};
      5:  return '{8'hCB, 4'd5,  7'd0};
      6:  return '{8'hF7, 4'd1,  7'd0};
      7:  return '{8'hEA, 4'd2,  7'd0};
      8:  return '{8'hC0, 4'd1,  7'd0};
      9:  return '{8'hC1, 4'd1,  7'd0};
      10: return '{8'hC5, 4'd2,  7'd0};
      11: return '{8'hC7, 4'd1,  7'd0};
      12: return '{8'h3A, 4'd1,  7'd0};
      13: return '{8'hB1, 4'd2,  7'd0};
      14: return '{8'h26, 4'd1,  7'd0};
      15: return '{8'hE0, 4'd15, 7'd0};
      16: return '{8'hE1, 4'd15, 7'd0};
      17: return '{8'hB7, 4'd1,  7'd0};
      18: return '{8'hB6, 4'd4,  7'd0};
      19: return '{8'h11, 4'd0,  7'd100};
      20: return '{8'h29, 4'd0,  7'd20};
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] gamma_byte(logic neg, int i);
    if (!neg) begin
      case (i)
        0: return 8'h1F;  1: return 8'h1A;  2: return 8'h18;  3: return 8'h0A;
        4: return 8'h0F;  5: return 8'h06;  6: return 8'h45;  7: return 8'h87;
        8: return 8'h32;  9: return 8'h0A; 10: return 8'h07; 11: return 8'h02;
        12: return 8'h07; 13: return 8'h05; default: return 8'h00;
      endcase
    end
    case (i)
      0: return 8'h00;  1: return 8'h25;  2: return 8'h27;  3: return 8'h05;
      4: return 8'h10;  5: return 8'h09;  6: return 8'h3A;  7: return 8'h78;
      8: return 8'h4D;  9: return 8'h05; 10: return 8'h18; 11: return 8'h0D;
      12: return 8'h38; 13: return 8'h3A; default: return 8'h1F;
    endcase
  endfunction

  function automatic logic [7:0] par_at(int i);
    if (i >= GPOS0 && i < GNEG0)        return gamma_byte(1'b0, i - GPOS0);
    if (i >= GNEG0 && i < GNEG0 + GLEN) return gamma_byte(1'b1, i - GNEG0);
    case (i)
      0: return 8'h00;  1: return 8'h83;  2: return 8'h30;
      3: return 8'h64;  4: return 8'h03;  5: return 8'h12;  6: return 8'h81;
      7: return 8'h85;  8: return 8'h01;  9: return 8'h79;
      10: return 8'h39; 11: return 8'h2C; 12: return 8'h00; 13: return 8'h34; 14: return 8'h02;
      15: return 8'h20;
      16: return 8'h00; 17: return 8'h00;
      18: return 8'h26;
      19: return 8'h11;
      20: return 8'h35; 21: return 8'h3E;
      22: return 8'hBE;
      23: return 8'h55;
      24: return 8'h00; 25: return 8'h1B;
      26: return 8'h01;
      57: return 8'h07;
      58: return 8'h0A; 59: return 8'h82; 60: return 8'h27; 61: return 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int unsigned ms_to_cycles(int unsigned ms, int unsigned cpm);
    return ms * cpm;
  endfunction

  function automatic int unsigned longest_table_wait();
    int unsigned m = 0;
    for (int i = 0; i < NSTEP; i++)
      if (int'(step_at(i).wait_ms) > int'(m)) m = int'(step_at(i).wait_ms);
    return m;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/lcdseq_ms_timer.sv
module lcdseq_ms_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (!zero)  cnt_q <= cnt_q - W'(1);
  end

  // R7: a running wait loses exactly one cycle per clock
  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R7: a loaded count is taken as given
  p_load_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int RST_MS      = 1,
  parameter int RST_WAIT_MS = 5,
  parameter int TW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          spi_idle,
  output logic          out_valid,
  input  logic          out_ready,
  output word_t         out_word,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  input  logic          t_zero,
  output logic          lcd_rst_n,
  output logic          busy,
  output logic          done
);

  localparam int SW = $clog2(NSTEP);
  localparam int PW = $clog2(NPAR);

  cstate_t     state_q;
  logic [SW-1:0] step_q;
  logic [PW-1:0] par_q;
  logic [3:0]    rem_q;
  step_t       cur;

  // named events for the assertions and the next-state logic
  logic start_take, word_fire, drained, last_step, step_over;

  assign cur        = step_at(int'(step_q));
  assign start_take = start && (state_q == C_IDLE);
  assign word_fire  = out_valid && out_ready;
  assign drained    = (state_q == C_FLUSH) && spi_idle;
  assign last_step  = (step_q == SW'(NSTEP - 1));
  assign step_over  = (drained && cur.wait_ms == '0) || (state_q == C_WAIT && t_zero);
  assign busy       = (state_q != C_IDLE);

  always_comb begin
    out_valid     = (state_q == C_CMD) || (state_q == C_PAR);
    out_word.dc   = (state_q == C_PAR);
    out_word.data = (state_q == C_PAR) ? par_at(int'(par_q)) : cur.code;
    out_word.last = (state_q == C_PAR) ? (rem_q == 4'd1) : (cur.npar == '0);
  end

  always_comb begin
    t_load = start_take || (state_q == C_RST && t_zero) || (drained && cur.wait_ms != '0);
    if (start_take)
      t_val = TW'(ms_to_cycles(RST_MS, CLKS_PER_MS) - 1);
    else if (state_q == C_RST)
      t_val = TW'(ms_to_cycles(RST_WAIT_MS, CLKS_PER_MS) - 1);
    else
      t_val = TW'(ms_to_cycles(int'(cur.wait_ms), CLKS_PER_MS) - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= C_IDLE;
      step_q    <= '0;
      par_q     <= '0;
      rem_q     <= '0;
      lcd_rst_n <= 1'b1;
      done      <= 1'b0;
    end else begin
      case (state_q)
        C_IDLE: if (start) begin
          state_q   <= C_RST;
          lcd_rst_n <= 1'b0;
          done      <= 1'b0;
          step_q    <= '0;
          par_q     <= '0;
        end
        C_RST: if (t_zero) begin
          lcd_rst_n <= 1'b1;
          state_q   <= C_RSTW;
        end
        C_RSTW: if (t_zero) state_q <= C_CMD;
        C_CMD: if (word_fire) begin
          if (cur.npar == '0) state_q <= C_FLUSH;
          else begin
            rem_q   <= cur.npar;
            state_q <= C_PAR;
          end
        end
        C_PAR: if (word_fire) begin
          par_q <= par_q + PW'(1);
          rem_q <= rem_q - 4'd1;
          if (rem_q == 4'd1) state_q <= C_FLUSH;
        end
        C_FLUSH: if (drained && cur.wait_ms != '0) state_q <= C_WAIT;
        default: ;
      endcase
      if (step_over) begin
        if (last_step) begin
          state_q <= C_IDLE;
          done    <= 1'b1;
        end else begin
          step_q  <= step_q + SW'(1);
          state_q <= C_CMD;
        end
      end
    end
  end

  // R4: an offered word is held until taken
  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R2: the panel reset is only driven during a run
  p_panel_rst_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n |-> busy);

  // R9: completion and activity never overlap
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: a start in mid-list does not pull the panel reset again
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q inside {C_CMD, C_PAR, C_FLUSH, C_WAIT}) |=> (lcd_rst_n && state_q != C_RST));

endmodule

// File: rtl/lcdseq_spi9.sv
module lcdseq_spi9
  import lcdseq_pkg::*;
#(
  parameter int SCK_HALF = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  word_t in_word,
  output logic  spi_idle,
  output logic  cs_n,
  output logic  sck,
  output logic  mosi
);

  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  sstate_t      st_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]   bit_q;
  logic [8:0]   sh_q;
  logic         last_q;
  logic         half_end, take;

  assign half_end = (cnt_q == CW'(SCK_HALF - 1));
  assign in_ready = (st_q == S_IDLE);
  assign take     = in_valid && in_ready;
  assign spi_idle = (st_q == S_IDLE) && cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
      cs_n   <= 1'b1;
      sck    <= 1'b0;
      mosi   <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (in_valid) begin
          sh_q   <= {in_word.dc, in_word.data};
          last_q <= in_word.last;
          cs_n   <= 1'b0;
          mosi   <= in_word.dc;
          bit_q  <= '0;
          cnt_q  <= '0;
          st_q   <= S_LOW;
        end
        S_LOW: begin
          if (half_end) begin
            cnt_q <= '0;
            sck   <= 1'b1;
            st_q  <= S_HIGH;
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_HIGH: begin
          if (half_end) begin
            cnt_q <= '0;
            sck   <= 1'b0;
            if (bit_q == 4'd8) st_q <= last_q ? S_TAIL : S_IDLE;
            else begin
              bit_q <= bit_q + 4'd1;
              sh_q  <= {sh_q[7:0], 1'b0};
              mosi  <= sh_q[7];
              st_q  <= S_LOW;
            end
          end else cnt_q <= cnt_q + CW'(1);
        end
        S_TAIL: begin
          if (half_end) begin
            cnt_q <= '0;
            cs_n  <= 1'b1;
            st_q  <= S_GAP;
          end else cnt_q <= cnt_q + CW'(1);
        end
        default: begin
          if (half_end) begin
            cnt_q <= '0;
            st_q  <= S_IDLE;
          end else cnt_q <= cnt_q + CW'(1);
        end
      endcase
    end
  end

  // R5: the clock rests low whenever the panel is deselected
  p_sck_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R5: data is frozen across a high clock phase
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  // R6: taking a word selects the panel
  p_cs_on_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !cs_n);

  // R6: the select only rises from a frame-closing state
  p_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (st_q == S_GAP));

endmodule

// File: rtl/lcdseq_top.sv
module lcdseq_top
  import lcdseq_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000,
  parameter int SCK_HALF    = 4,
  parameter int RST_MS      = 1,
  parameter int RST_WAIT_MS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic lcd_rst_n,
  output logic spi_cs_n,
  output logic spi_sck,
  output logic spi_mosi
);

  localparam int unsigned MAX_MS = max3(longest_table_wait(), RST_MS, RST_WAIT_MS);
  localparam int TW = $clog2(MAX_MS * CLKS_PER_MS + 1);

  logic          w_valid, w_ready, spi_idle;
  word_t         w_word;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;

  lcdseq_ctrl #(
    .CLKS_PER_MS(CLKS_PER_MS),
    .RST_MS     (RST_MS),
    .RST_WAIT_MS(RST_WAIT_MS),
    .TW         (TW)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .spi_idle (spi_idle),
    .out_valid(w_valid),
    .out_ready(w_ready),
    .out_word (w_word),
    .t_load   (t_load),
    .t_val    (t_val),
    .t_zero   (t_zero),
    .lcd_rst_n(lcd_rst_n),
    .busy     (busy),
    .done     (done)
  );

  lcdseq_ms_timer #(.W(TW)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (t_load),
    .load_val(t_val),
    .zero    (t_zero)
  );

  lcdseq_spi9 #(.SCK_HALF(SCK_HALF)) spi_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(w_valid),
    .in_ready(w_ready),
    .in_word (w_word),
    .spi_idle(spi_idle),
    .cs_n    (spi_cs_n),
    .sck     (spi_sck),
    .mosi    (spi_mosi)
  );

endmodule

// File: tb/lcdseq_top_tb_top.sv
module lcdseq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 20;
  localparam int HALF       = 2;
  localparam int RMS        = 1;
  localparam int RWMS       = 5;
  localparam int NFRAMES    = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, lcd_rst_n, spi_cs_n, spi_sck, spi_mosi;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdseq_top #(
    .CLKS_PER_MS(CPM), .SCK_HALF(HALF), .RST_MS(RMS), .RST_WAIT_MS(RWMS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .lcd_rst_n(lcd_rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  // scoreboard entries: {end of frame, dc, byte}
  logic [9:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic int wait_of(logic [7:0] c);
    case (c)
      8'h01: return 5;
      8'h11: return 100;
      8'h29: return 20;
      default: return 0;
    endcase
  endfunction

  task automatic push_frame(input logic [7:0] c, input int n, input logic [119:0] p);
    exp_q.push_back({(n == 0), 1'b0, c});
    for (int k = 0; k < n; k++)
      exp_q.push_back({(k == n - 1), 1'b1, p[119 - 8*k -: 8]});
  endtask

  // driver side of the scoreboard: R3 order, R11 gamma contents
  task automatic load_list();
    push_frame(8'h01, 0, 120'h0);
    push_frame(8'h28, 0, 120'h0);
    push_frame(8'hCF, 3, {8'h00, 8'h83, 8'h30, 96'h0});
    push_frame(8'hED, 4, {8'h64, 8'h03, 8'h12, 8'h81, 88'h0});
    push_frame(8'hE8, 3, {8'h85, 8'h01, 8'h79, 96'h0});
    push_frame(8'hCB, 5, {8'h39, 8'h2C, 8'h00, 8'h34, 8'h02, 80'h0});
    push_frame(8'hF7, 1, {8'h20, 112'h0});
    push_frame(8'hEA, 2, {8'h00, 8'h00, 104'h0});
    push_frame(8'hC0, 1, {8'h26, 112'h0});
    push_frame(8'hC1, 1, {8'h11, 112'h0});
    push_frame(8'hC5, 2, {8'h35, 8'h3E, 104'h0});
    push_frame(8'hC7, 1, {8'hBE, 112'h0});
    push_frame(8'h3A, 1, {8'h55, 112'h0});
    push_frame(8'hB1, 2, {8'h00, 8'h1B, 104'h0});
    push_frame(8'h26, 1, {8'h01, 112'h0});
    push_frame(8'hE0, 15, {8'h1F, 8'h1A, 8'h18, 8'h0A, 8'h0F, 8'h06, 8'h45, 8'h87,
                           8'h32, 8'h0A, 8'h07, 8'h02, 8'h07, 8'h05, 8'h00});
    push_frame(8'hE1, 15, {8'h00, 8'h25, 8'h27, 8'h05, 8'h10, 8'h09, 8'h3A, 8'h78,
                           8'h4D, 8'h05, 8'h18, 8'h0D, 8'h38, 8'h3A, 8'h1F});
    push_frame(8'hB7, 1, {8'h07, 112'h0});
    push_frame(8'hB6, 4, {8'h0A, 8'h82, 8'h27, 8'h00, 88'h0});
    push_frame(8'h11, 0, 120'h0);
    push_frame(8'h29, 0, 120'h0);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor state
  logic       p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0, p_lrst = 1'b1, p_done = 1'b0;
  logic [8:0] shreg = '0;
  logic [9:0] item;
  logic       last_seen = 1'b0;
  logic [7:0] frame_cmd = '0, prev_cmd = '0;
  int bitcnt = 0, frames = 0, cs_rise_cyc = 0, rst_fall_cyc = 0, rst_rise_cyc = 0, high_cyc = 0;
  bit first_pending = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!lcd_rst_n && p_lrst) rst_fall_cyc = cyc;
      if (lcd_rst_n && !p_lrst) begin
        chk(cyc - rst_fall_cyc == RMS*CPM, "R2", "panel reset low cycles",
            cyc - rst_fall_cyc, RMS*CPM);
        rst_rise_cyc  = cyc;
        first_pending = 1'b1;
      end
      if (!spi_cs_n && p_cs) begin
        if (first_pending) begin
          chk(cyc - rst_rise_cyc >= RWMS*CPM && cyc - rst_rise_cyc <= RWMS*CPM + 4,
              "R2", "recovery before first frame", cyc - rst_rise_cyc, RWMS*CPM);
          first_pending = 1'b0;
        end else if (wait_of(prev_cmd) != 0) begin
          chk(cyc - cs_rise_cyc >= wait_of(prev_cmd)*CPM &&
              cyc - cs_rise_cyc <= wait_of(prev_cmd)*CPM + HALF + 4,
              "R7", "timed gap after command", cyc - cs_rise_cyc, wait_of(prev_cmd)*CPM);
        end else begin
          chk(cyc - cs_rise_cyc <= HALF + 4, "R8", "gap between commands",
              cyc - cs_rise_cyc, HALF + 4);
        end
        bitcnt = 0;
      end
      if (spi_sck && !p_sck) begin
        chk(!spi_cs_n, "R6", "clock edge while deselected", spi_cs_n, 0);
        shreg  = {shreg[7:0], spi_mosi};
        bitcnt = bitcnt + 1;
        high_cyc = cyc;
        if (bitcnt % 9 == 0) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "word beyond end of list", {1'b0, shreg}, 0);
          end else begin
            item = exp_q.pop_front();
            chk(shreg == item[8:0], item[8] ? "R4" : "R3", "decoded word {dc,byte}",
                shreg, item[8:0]);
            if (bitcnt == 9) frame_cmd = shreg[7:0];
            last_seen = item[9];
          end
        end
      end
      if (!spi_sck && p_sck)
        chk(cyc - high_cyc == HALF, "R5", "sck high cycles", cyc - high_cyc, HALF);
      if (spi_sck && p_sck && spi_mosi != p_mosi)
        chk(1'b0, "R5", "mosi moved while sck high", spi_mosi, p_mosi);
      if (spi_cs_n && !p_cs) begin
        chk(bitcnt > 0 && bitcnt % 9 == 0 && last_seen, "R6",
            "select rose at a command boundary (bits)", bitcnt, 9);
        frames++;
        cs_rise_cyc = cyc;
        prev_cmd    = frame_cmd;
      end
      if (done && !p_done) begin
        chk(prev_cmd == 8'h29, "R7", "command before done", prev_cmd, 8'h29);
        chk(cyc - cs_rise_cyc >= 20*CPM && cyc - cs_rise_cyc <= 20*CPM + HALF + 4,
            "R7", "wait before done", cyc - cs_rise_cyc, 20*CPM);
        chk(!busy, "R9", "busy low at done", busy, 0);
      end
    end
    p_cs = spi_cs_n; p_sck = spi_sck; p_mosi = spi_mosi; p_lrst = lcd_rst_n; p_done = done;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R1", "sck after reset", spi_sck, 0);
    chk(lcd_rst_n == 1'b1, "R1", "lcd_rst_n after reset", lcd_rst_n, 1);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset", {busy, done}, 0);

    load_list();
    pulse_start();
    chk(busy == 1'b1 && lcd_rst_n == 1'b0, "R2", "reset driven after start",
        {busy, lcd_rst_n}, 2'b10);

    wait (frames >= 5);
    pulse_start();  // R10: ignored while busy
    repeat (3) @(negedge clk);
    chk(busy == 1'b1 && lcd_rst_n == 1'b1, "R10", "mid-run start ignored",
        {busy, lcd_rst_n}, 2'b11);

    wait (done);
    @(negedge clk);
    chk(exp_q.size() == 0, "R3", "words left unsent", exp_q.size(), 0);
    chk(frames == NFRAMES, "R6", "frame count first run", frames, NFRAMES);
    repeat (40) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R9", "done held while idle", {done, busy}, 2'b10);

    // second run: done clears on start
    load_list();
    pulse_start();
    chk(done == 1'b0 && busy == 1'b1, "R9", "done cleared by start", {done, busy}, 2'b01);
    wait (done);
    @(negedge clk);
    chk(exp_q.size() == 0, "R11", "words left unsent second run", exp_q.size(), 0);
    chk(frames == 2*NFRAMES, "R6", "frame count second run", frames, 2*NFRAMES);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule